// File: doc/BRIEF.md
# Page Program Data Buffer

This block gathers the data phase of a page program command for a serial NOR flash. After the command decoder has taken in the opcode and the three address bytes, it pulses `cmdStart` with the target address. Data bits then arrive one per strobe on `dqIn0` in standard mode, or two per strobe on `dqIn1`/`dqIn0` in dual-input mode. Each completed byte is placed in an internal page buffer. The offset starts at the low address bits and wraps inside the page, so when more than a page of data is sent, only the most recent page-worth of bytes is kept.

When the command ends (`cmdEnd`), the block checks how much data arrived. If at least one whole byte arrived and no byte was left half-received, the block enters a self-timed commit of fixed length with `busy` high. During the commit it sweeps every offset of the page. For each offset that received data, it reads the old array byte and writes back the bitwise AND of the old byte and the new data, because programming can only clear bits. Offsets that received nothing are not written. If the command ends with a partial byte or with no data at all, it is dropped and nothing is written.

Top module: `pp_buffer`

## Requirements
- R1: After reset, `busy` and `arrWrEn` are 0, and no array write happens until a command commits.
- R2: In standard mode (`dualMode`=0 at `cmdStart`), each `bitStrobe` shifts in one bit from `dqIn0`. Bytes are assembled most significant bit first, and eight strobes make one byte.
- R3: In dual mode (`dualMode`=1 at `cmdStart`), each `bitStrobe` shifts in a bit pair. `dqIn1` carries the higher bit of the pair and the pair nearest the MSB comes first, so four strobes make one byte.
- R4: The first byte goes to page offset `startAddr[7:0]`, and each later byte goes to the next offset modulo 256. The page number `startAddr[ADDR_W-1:8]` never changes during a command.
- R5: When more than 256 bytes are sent, each offset holds the last byte sent to it, so the final 256 bytes are the ones programmed.
- R6: Array bytes at offsets that received no data in the command, and bytes in other pages, stay unchanged after the commit.
- R7: Each programmed array byte becomes (old byte AND new byte). No write ever sets a bit that is 0 in the array.
- R8: A committing `cmdEnd` raises `busy` on the next cycle. `busy` stays high for exactly PAGE_BYTES (256) cycles, and array writes occur only while `busy` is high.
- R9: If `cmdEnd` arrives with a partial byte pending, or with no complete byte received, the command is discarded. In that case `busy` stays 0 and the array is unchanged.
- R10: `cmdStart`, `bitStrobe` and `cmdEnd` are ignored while `busy` is high. The commit length and its result are unaffected, and no new commit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Pulse: data phase begins, captures startAddr and dualMode |
| startAddr | input | ADDR_W | Target array address of the first data byte |
| dualMode | input | 1 | 1 = two bits per strobe, 0 = one bit per strobe |
| bitStrobe | input | 1 | One serial clock's worth of data is valid on dqIn0/dqIn1 |
| dqIn0 | input | 1 | Serial data bit (low bit of a pair in dual mode) |
| dqIn1 | input | 1 | High bit of a pair in dual mode, unused in standard mode |
| cmdEnd | input | 1 | Pulse: chip select released, command ends |
| busy | output | 1 | Commit cycle in progress (write-in-progress) |
| arrRdAddr | output | ADDR_W | Array read address during commit |
| arrRdData | input | 8 | Array byte at arrRdAddr, combinational |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | 8 | Byte written to the array |

## Verification
A stale valid mark or a wrong offset counter shows up at the ports during the next commit. Bytes land at the wrong offset, bytes that should survive are missing, or a write hits an offset that received nothing. A full array compare after each commit finds all of these within the PAGE_BYTES cycles of that commit. A wrong bit counter shows up sooner: it either turns an abort into a commit or turns a commit into an abort, and `busy` reveals this one cycle after `cmdEnd`. A controller that fails to ignore inputs while busy shows up as a commit of the wrong length, or as a second `busy` pulse after the first one ends.

// File: rtl/pp_buffer_pkg.sv
package pp_buffer_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic startCmd;
    logic shiftBits;
    logic commitGo;
    logic commitStep;
  } ppStrobe_t;
endpackage

// File: rtl/pp_buffer_ctrl.sv
module pp_buffer_ctrl
  import pp_buffer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStart,
  input  logic      bitStrobe,
  input  logic      cmdEnd,
  input  logic      byteSeen,
  input  logic      bitsPending,
  input  logic      lastPtr,
  output ppStrobe_t strb,
  output logic      busy
);
  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_COMMIT} ppState_e;

  ppState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdStart) begin
          strb.startCmd = 1'b1;
          stateNext     = S_COLLECT;
        end
      end
      S_COLLECT: begin
        if (cmdStart) begin
          strb.startCmd = 1'b1;
        end else if (cmdEnd) begin
          if (byteSeen && !bitsPending) begin
            strb.commitGo = 1'b1;
            stateNext     = S_COMMIT;
          end else begin
            stateNext = S_IDLE;
          end
        end else if (bitStrobe) begin
          strb.shiftBits = 1'b1;
        end
      end
      S_COMMIT: begin
        strb.commitStep = 1'b1;
        if (lastPtr) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state == S_COMMIT);
endmodule

// File: rtl/pp_buffer_dp.sv
module pp_buffer_dp
  import pp_buffer_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobe_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dualMode,
  input  logic              dqIn0,
  input  logic              dqIn1,
  input  logic [BYTE_W-1:0] arrRdData,
  output logic              byteSeen,
  output logic              bitsPending,
  output logic              lastPtr,
  output logic [ADDR_W-1:0] arrRdAddr,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [BYTE_W-1:0] arrWrData
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [OFF_W-1:0] PTR_LAST = OFF_W'(PAGE_BYTES - 1);

  logic [PAGE_W-1:0]     pageBase;
  logic [OFF_W-1:0]      offset;
  logic [OFF_W-1:0]      ptr;
  logic [BYTE_W-1:0]     shReg, shNext;
  logic [CNT_W-1:0]      bitCnt, cntNext;
  logic                  dualLatched;
  logic [PAGE_BYTES-1:0] validMask;
  logic [BYTE_W-1:0]     dataBuf [PAGE_BYTES];

  always_comb begin
    if (dualLatched) begin
      shNext  = {shReg[BYTE_W-3:0], dqIn1, dqIn0};
      cntNext = bitCnt + CNT_W'(2);
    end else begin
      shNext  = {shReg[BYTE_W-2:0], dqIn0};
      cntNext = bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase    <= '0;
      offset      <= '0;
      ptr         <= '0;
      shReg       <= '0;
      bitCnt      <= '0;
      dualLatched <= 1'b0;
      byteSeen    <= 1'b0;
      validMask   <= '0;
    end else begin
      if (strb.startCmd) begin
        pageBase    <= startAddr[ADDR_W-1:OFF_W];
        offset      <= startAddr[OFF_W-1:0];
        shReg       <= '0;
        bitCnt      <= '0;
        dualLatched <= dualMode;
        byteSeen    <= 1'b0;
        validMask   <= '0;
      end
      if (strb.shiftBits) begin
        if (cntNext == CNT_FULL) begin
          validMask[offset] <= 1'b1;
          offset            <= offset + OFF_W'(1);
          bitCnt            <= '0;
          shReg             <= '0;
          byteSeen          <= 1'b1;
        end else begin
          shReg  <= shNext;
          bitCnt <= cntNext;
        end
      end
      if (strb.commitGo)   ptr <= '0;
      if (strb.commitStep) ptr <= ptr + OFF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.shiftBits && (cntNext == CNT_FULL)) dataBuf[offset] <= shNext;
  end

  assign bitsPending = (bitCnt != '0);
  assign lastPtr     = (ptr == PTR_LAST);
  assign arrRdAddr   = {pageBase, ptr};
  assign arrWrAddr   = {pageBase, ptr};
  assign arrWrEn     = strb.commitStep && validMask[ptr];
  assign arrWrData   = arrRdData & dataBuf[ptr];
endmodule

// File: rtl/pp_buffer.sv
module pp_buffer
  import pp_buffer_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dualMode,
  input  logic              bitStrobe,
  input  logic              dqIn0,
  input  logic              dqIn1,
  input  logic              cmdEnd,
  output logic              busy,
  output logic [ADDR_W-1:0] arrRdAddr,
  input  logic [BYTE_W-1:0] arrRdData,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [BYTE_W-1:0] arrWrData
);
  ppStrobe_t strb;
  logic      byteSeen, bitsPending, lastPtr;

  pp_buffer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .bitStrobe(bitStrobe),
    .cmdEnd(cmdEnd), .byteSeen(byteSeen), .bitsPending(bitsPending),
    .lastPtr(lastPtr), .strb(strb), .busy(busy)
  );

  pp_buffer_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .dualMode(dualMode), .dqIn0(dqIn0), .dqIn1(dqIn1),
    .arrRdData(arrRdData), .byteSeen(byteSeen), .bitsPending(bitsPending),
    .lastPtr(lastPtr), .arrRdAddr(arrRdAddr), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );
endmodule

// File: rtl/pp_buffer_chk.sv
module pp_buffer_chk #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdEnd,
  input logic              busy,
  input logic [ADDR_W-1:0] arrRdAddr,
  input logic [7:0]        arrRdData,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr,
  input logic [7:0]        arrWrData
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 32'd1;
    else           busyRun <= '0;
  end

  // R8: array writes only inside the commit window
  a_r8_write_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  // R8: a commit is always started by an end-of-command strobe
  a_r8_busy_from_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdEnd));

  // R8: commit window length is one page sweep
  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 32'(PAGE_BYTES)));

  // R7: a write never sets a bit the array holds at 0, and targets the byte read
  a_r7_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (((arrWrData & ~arrRdData) == 8'h00) && (arrWrAddr == arrRdAddr)));

  // R4: the page number holds for the whole commit
  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (arrRdAddr[ADDR_W-1:OFF_W] == $past(arrRdAddr[ADDR_W-1:OFF_W])));
endmodule

bind pp_buffer pp_buffer_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .cmdEnd(cmdEnd), .busy(busy),
  .arrRdAddr(arrRdAddr), .arrRdData(arrRdData), .arrWrEn(arrWrEn),
  .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
);

// File: tb/pp_buffer_tb.sv
`timescale 1ns/1ps
module pp_buffer_tb;
  localparam int AW    = 12;
  localparam int PAGE  = 256;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdStart = 1'b0, dualMode = 1'b0, bitStrobe = 1'b0;
  logic          dqIn0 = 1'b0, dqIn1 = 1'b0, cmdEnd = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          busy, arrWrEn;
  logic [AW-1:0] arrRdAddr, arrWrAddr;
  logic [7:0]    arrRdData, arrWrData;

  logic [7:0] mem    [MEMSZ];
  logic [7:0] expMem [MEMSZ];
  logic [7:0] newB   [PAGE];
  logic       newV   [PAGE];

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pp_buffer #(.ADDR_W(AW), .PAGE_BYTES(PAGE)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .dualMode(dualMode), .bitStrobe(bitStrobe), .dqIn0(dqIn0), .dqIn1(dqIn1),
    .cmdEnd(cmdEnd), .busy(busy), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  assign arrRdData = mem[arrRdAddr];
  always @(posedge clk) if (arrWrEn) mem[arrWrAddr] <= arrWrData;

  function automatic logic [7:0] dataOf(int k, int seed);
    return 8'((k * 37 + seed * 11 + 5) ^ (k >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compareMem(input string req);
    int miss = 0;
    int firstA = -1;
    for (int i = 0; i < MEMSZ; i++)
      if (mem[i] !== expMem[i]) begin
        miss++;
        if (firstA < 0) firstA = i;
      end
    if (firstA < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " mem"}, int'(mem[firstA]), int'(expMem[firstA]));
  endtask

  // send nBytes whole bytes, then extra partial strobes, then end the command
  task automatic runCmd(input int addr, input bit dual, input int nBytes,
                        input int extra, input int seed, input bit disturb,
                        input string req);
    int step = dual ? 2 : 1;
    int busyCnt = 0;
    bit commit;
    for (int i = 0; i < PAGE; i++) newV[i] = 1'b0;
    @(negedge clk);
    cmdStart = 1'b1; startAddr = AW'(addr); dualMode = dual;
    @(negedge clk);
    cmdStart = 1'b0; dualMode = 1'b0;
    for (int k = 0; k < nBytes; k++) begin
      logic [7:0] b = dataOf(k, seed);
      newB[(addr + k) % PAGE] = b;
      newV[(addr + k) % PAGE] = 1'b1;
      for (int p = 8 - step; p >= 0; p -= step) begin
        bitStrobe = 1'b1;
        dqIn0 = b[p];
        dqIn1 = dual ? b[p + 1] : 1'b0;
        @(negedge clk);
      end
    end
    for (int e = 0; e < extra; e++) begin
      bitStrobe = 1'b1; dqIn0 = 1'b1; dqIn1 = 1'b1;
      @(negedge clk);
    end
    bitStrobe = 1'b0; dqIn0 = 1'b0; dqIn1 = 1'b0;
    cmdEnd = 1'b1;
    @(negedge clk);
    cmdEnd = 1'b0;
    commit = (nBytes > 0) && (extra == 0);
    if (commit) begin
      int pb = addr - (addr % PAGE);
      for (int o = 0; o < PAGE; o++)
        if (newV[o]) expMem[pb + o] = expMem[pb + o] & newB[o];
    end
    check(busy == commit, {req, " R8 busy after end"}, int'(busy), int'(commit));
    while (busy) begin
      busyCnt++;
      if (disturb) begin
        cmdStart  = (busyCnt % 7 == 3);
        startAddr = AW'(12'h0F0);
        cmdEnd    = (busyCnt % 5 == 1);
        bitStrobe = 1'b1;
        dqIn0     = busyCnt[0];
      end
      @(negedge clk);
      if (busyCnt > 4 * PAGE) break;
    end
    cmdStart = 1'b0; cmdEnd = 1'b0; bitStrobe = 1'b0; dqIn0 = 1'b0;
    check(busyCnt == (commit ? PAGE : 0), {req, " R8 busy length"}, busyCnt, commit ? PAGE : 0);
    repeat (12) begin
      @(negedge clk);
      if (busy) break;
    end
    check(!busy, {req, " R10 no further commit"}, int'(busy), 0);
    compareMem(req);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i]    = 8'((i * 13 + 7) ^ (i >> 4) ^ 8'hF5);
      expMem[i] = 8'((i * 13 + 7) ^ (i >> 4) ^ 8'hF5);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(arrWrEn == 1'b0, "R1 write in reset", int'(arrWrEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && arrWrEn == 1'b0, "R1 idle after reset", int'({busy, arrWrEn}), 0);
    compareMem("R1 array untouched");

    runCmd(12'h105, 1'b0,   4, 0, 1, 1'b0, "R2 single mode");
    runCmd(12'h230, 1'b1,   6, 0, 2, 1'b0, "R3 dual mode");
    runCmd(12'h3FC, 1'b0,   9, 0, 3, 1'b0, "R4 offset wrap");
    runCmd(12'h4A0, 1'b0, 300, 0, 4, 1'b0, "R5 overlong single");
    runCmd(12'h500, 1'b1, 515, 0, 5, 1'b0, "R5 overlong dual");
    runCmd(12'h600, 1'b1, 256, 0, 6, 1'b0, "R6 full page");
    runCmd(12'h7C0, 1'b0,   1, 0, 7, 1'b0, "R6 single byte");
    runCmd(12'h700, 1'b0,   3, 5, 8, 1'b0, "R9 partial single");
    runCmd(12'h710, 1'b0,   0, 0, 9, 1'b0, "R9 no data");
    runCmd(12'h720, 1'b1,   2, 1, 10, 1'b0, "R9 partial dual");
    runCmd(12'h820, 1'b0,  10, 0, 11, 1'b1, "R10 inputs while busy");
    runCmd(12'h105, 1'b1,   4, 0, 12, 1'b0, "R7 and with old");
    runCmd(12'h106, 1'b0,   2, 0, 13, 1'b0, "R7 repeat program");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule